// File: doc/BRIEF.md
# Shifted-Operand Accumulator Subtract Unit

This block keeps a 32-bit accumulator together with four status flags (zero, negative, carry, overflow) and a small signed overflow counter. Each accepted operation takes a 16-bit operand and widens it to 32 bits, by sign or by zero extension. It then moves the operand left by 0 to 16 places, filling the low end with zeros, and subtracts it from the accumulator. The flags and the counter are updated from that subtraction. An overflow-mode input chooses what happens on signed overflow: the result wraps and the counter moves one step, or the result saturates and the counter stays as it is.

A repeat count makes one request run several times. A count of N gives N+1 subtractions on consecutive clock edges, all with the operand and modes captured when the request was accepted. A small sequencer has two states. In `ST_IDLE` the unit accepts work. In `ST_REPEAT` it runs the remaining passes and raises `busy`. The transition *start-repeat* (`ST_IDLE` to `ST_REPEAT`) is taken when an accepted request carries a non-zero count. The transition *step* (`ST_REPEAT` to `ST_REPEAT`) is taken while more than one pass remains. The transition *finish* (`ST_REPEAT` to `ST_IDLE`) is taken on the last pass. A request with a zero count stays in `ST_IDLE` (*single*). A load port writes the accumulator, flags and counter directly, so tests can start from any state.

Top module: `shacc_sub_unit`

## Requirements
- R1: After reset the accumulator, all four flags and the overflow counter read zero, and `busy` is low.
- R2: The operand is widened to 32 bits: `sign_ext`=1 copies bit 15 into bits 31..16, and `sign_ext`=0 puts zeros there. It is then shifted left by `op_shift` with zeros shifted in. Shift values 17 to 31 act as 16.
- R3: Without saturation, an accepted operation sets the accumulator to the old accumulator minus the shifted operand, modulo 2^32, at the next clock edge.
- R4: After every operation, `flag_z` is 1 exactly when the accumulator is zero, and `flag_n` equals accumulator bit 31.
- R5: For effective shifts 0 to 15, `flag_c` becomes 0 when the subtraction borrows (the old accumulator is below the operand, both read as unsigned) and 1 otherwise.
- R6: For an effective shift of 16, a borrow clears `flag_c`, and no borrow leaves `flag_c` unchanged.
- R7: `flag_v` is set when the true signed difference lies outside the 32-bit signed range. It is never cleared by an operation.
- R8: With `sat_mode`=0, a positive overflow adds one to `ovc` and a negative overflow subtracts one. `ovc` is 6-bit two's complement and wraps.
- R9: With `sat_mode`=1, `ovc` does not change. A positive overflow leaves 0x7FFFFFFF in the accumulator, and a negative overflow leaves 0x80000000.
- R10: A request with `rpt_cnt`=N performs N+1 subtractions on consecutive edges with the captured operand, shift and modes. `busy` is high for the N cycles after acceptance and low afterwards.
- R11: While `busy` is high, `op_valid` and `ld_en` have no effect.
- R12: While idle, `ld_en` writes `ld_acc`, `ld_ovc` and `ld_flags` at the next edge, with `ld_flags` bit 3 = Z, bit 2 = N, bit 1 = C and bit 0 = V. It takes priority over `op_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Direct load strobe |
| ld_acc | input | 32 | Accumulator load value |
| ld_flags | input | 4 | Flag load value {Z,N,C,V} |
| ld_ovc | input | 6 | Overflow counter load value |
| op_valid | input | 1 | Operation request |
| op_data | input | 16 | Operand |
| op_shift | input | 5 | Left shift amount |
| sign_ext | input | 1 | 1 = sign extend operand |
| sat_mode | input | 1 | 1 = saturate on overflow |
| rpt_cnt | input | 8 | Extra repetitions |
| busy | output | 1 | Repeat in progress |
| acc | output | 32 | Accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry (no-borrow) flag |
| flag_v | output | 1 | Sticky overflow flag |
| ovc | output | 6 | Signed overflow counter |

## Verification
The hardest states to reach from the ports are those where the overflow counter wraps, where a 16-place shift meets an already-clear or already-set carry, and where overflow happens with the carry and sticky flag already set. Before every operation the load port sets the accumulator and all flags and the counter to chosen values. A sweep then covers each combination of operand corner values, accumulator corner values, every shift amount including an out-of-range one, and both mode bits. Repeat runs with competing requests and loads during `busy` exercise the sequencer.

// File: rtl/shsub_pkg.sv
package shsub_pkg;
    localparam int DEF_OP_W    = 16;
    localparam int DEF_ACC_W   = 32;
    localparam int DEF_SHIFT_W = 5;
    localparam int DEF_OVC_W   = 6;
    localparam int DEF_RPT_W   = 8;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPEAT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } flags_t;
endpackage

// File: rtl/shsub_align.sv
module shsub_align #(
    parameter int OP_W    = shsub_pkg::DEF_OP_W,
    parameter int ACC_W   = shsub_pkg::DEF_ACC_W,
    parameter int SHIFT_W = shsub_pkg::DEF_SHIFT_W
) (
    input  logic [OP_W-1:0]    data_in,
    input  logic [SHIFT_W-1:0] shift_in,
    input  logic               sx_in,
    output logic [ACC_W-1:0]   aligned,
    output logic               full_shift
);
    localparam logic [SHIFT_W-1:0] MAX_SH = SHIFT_W'(OP_W);

    logic [ACC_W-1:0]   widened;
    logic [SHIFT_W-1:0] amt;

    assign widened[OP_W-1:0] = data_in;

    // upper bits replicate the operand sign only in sign-extension mode
    for (genvar gi = OP_W; gi < ACC_W; gi++) begin : g_ext
        assign widened[gi] = sx_in & data_in[OP_W-1];
    end

    always_comb begin
        amt        = (shift_in > MAX_SH) ? MAX_SH : shift_in;
        full_shift = (amt == MAX_SH);
        aligned    = widened << amt;
    end
endmodule

// File: rtl/shsub_core.sv
module shsub_core #(
    parameter int ACC_W = shsub_pkg::DEF_ACC_W,
    parameter int OVC_W = shsub_pkg::DEF_OVC_W
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic             c_in,
    input  logic             v_in,
    input  logic [OVC_W-1:0] ovc_in,
    input  logic [ACC_W-1:0] opnd,
    input  logic             full_shift,
    input  logic             sat_in,
    output logic [ACC_W-1:0] acc_nx,
    output shsub_pkg::flags_t flags_nx,
    output logic [OVC_W-1:0] ovc_nx,
    output logic             pos_ovf,
    output logic             neg_ovf
);
    localparam logic [ACC_W-1:0] MAX_POS = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MAX_NEG = {1'b1, {(ACC_W-1){1'b0}}};

    logic [ACC_W:0]   wide_diff;
    logic [ACC_W-1:0] diff;
    logic             borrow;
    logic             a_s, b_s, d_s;

    always_comb begin
        wide_diff = {1'b0, acc_in} - {1'b0, opnd};
        diff      = wide_diff[ACC_W-1:0];
        borrow    = wide_diff[ACC_W];
        a_s       = acc_in[ACC_W-1];
        b_s       = opnd[ACC_W-1];
        d_s       = diff[ACC_W-1];
        pos_ovf   = !a_s &&  b_s &&  d_s;
        neg_ovf   =  a_s && !b_s && !d_s;

        if (sat_in && pos_ovf)      acc_nx = MAX_POS;
        else if (sat_in && neg_ovf) acc_nx = MAX_NEG;
        else                        acc_nx = diff;

        if (sat_in)       ovc_nx = ovc_in;
        else if (pos_ovf) ovc_nx = ovc_in + OVC_W'(1);
        else if (neg_ovf) ovc_nx = ovc_in - OVC_W'(1);
        else              ovc_nx = ovc_in;

        flags_nx.z = (acc_nx == '0);
        flags_nx.n = acc_nx[ACC_W-1];
        flags_nx.v = v_in | pos_ovf | neg_ovf;
        if (full_shift) flags_nx.c = c_in & ~borrow;
        else            flags_nx.c = ~borrow;
    end
endmodule

// File: rtl/shsub_seq.sv
module shsub_seq #(
    parameter int OP_W    = shsub_pkg::DEF_OP_W,
    parameter int SHIFT_W = shsub_pkg::DEF_SHIFT_W,
    parameter int RPT_W   = shsub_pkg::DEF_RPT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic               op_valid,
    input  logic [OP_W-1:0]    op_data,
    input  logic [SHIFT_W-1:0] op_shift,
    input  logic               sign_ext,
    input  logic               sat_mode,
    input  logic [RPT_W-1:0]   rpt_cnt,
    output logic               fire,
    output logic               ld_take,
    output logic               busy,
    output logic [OP_W-1:0]    sel_data,
    output logic [SHIFT_W-1:0] sel_shift,
    output logic               sel_sx,
    output logic               sel_sat
);
    import shsub_pkg::*;

    seq_state_e         state, state_nx;
    logic [RPT_W-1:0]   remain;
    logic [OP_W-1:0]    hold_data;
    logic [SHIFT_W-1:0] hold_shift;
    logic               hold_sx, hold_sat;
    logic               accept;

    assign accept = (state == ST_IDLE) && op_valid && !ld_en;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept && rpt_cnt != '0) state_nx = ST_REPEAT;
            ST_REPEAT: if (remain == RPT_W'(1))     state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // state register and captured request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            remain     <= '0;
            hold_data  <= '0;
            hold_shift <= '0;
            hold_sx    <= 1'b0;
            hold_sat   <= 1'b0;
        end else begin
            state <= state_nx;
            if (accept) begin
                remain     <= rpt_cnt;
                hold_data  <= op_data;
                hold_shift <= op_shift;
                hold_sx    <= sign_ext;
                hold_sat   <= sat_mode;
            end else if (state == ST_REPEAT) begin
                remain <= remain - RPT_W'(1);
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_IDLE: begin
                busy      = 1'b0;
                fire      = accept;
                ld_take   = ld_en;
                sel_data  = op_data;
                sel_shift = op_shift;
                sel_sx    = sign_ext;
                sel_sat   = sat_mode;
            end
            ST_REPEAT: begin
                busy      = 1'b1;
                fire      = 1'b1;
                ld_take   = 1'b0;
                sel_data  = hold_data;
                sel_shift = hold_shift;
                sel_sx    = hold_sx;
                sel_sat   = hold_sat;
            end
            default: begin
                busy      = 1'b0;
                fire      = 1'b0;
                ld_take   = 1'b0;
                sel_data  = op_data;
                sel_shift = op_shift;
                sel_sx    = sign_ext;
                sel_sat   = sat_mode;
            end
        endcase
    end

    // R10
    rep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT && remain > RPT_W'(1)) |=>
            (state == ST_REPEAT && remain == $past(remain) - RPT_W'(1)));

    // R10
    rep_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT && remain == RPT_W'(1)) |=> (state == ST_IDLE));

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REPEAT) |=>
            ($stable(hold_data) && $stable(hold_shift) && $stable(hold_sx) && $stable(hold_sat)));
endmodule

// File: rtl/shacc_sub_unit.sv
module shacc_sub_unit #(
    parameter int OP_W    = shsub_pkg::DEF_OP_W,
    parameter int ACC_W   = shsub_pkg::DEF_ACC_W,
    parameter int SHIFT_W = shsub_pkg::DEF_SHIFT_W,
    parameter int OVC_W   = shsub_pkg::DEF_OVC_W,
    parameter int RPT_W   = shsub_pkg::DEF_RPT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [ACC_W-1:0]   ld_acc,
    input  logic [3:0]         ld_flags,
    input  logic [OVC_W-1:0]   ld_ovc,
    input  logic               op_valid,
    input  logic [OP_W-1:0]    op_data,
    input  logic [SHIFT_W-1:0] op_shift,
    input  logic               sign_ext,
    input  logic               sat_mode,
    input  logic [RPT_W-1:0]   rpt_cnt,
    output logic               busy,
    output logic [ACC_W-1:0]   acc,
    output logic               flag_z,
    output logic               flag_n,
    output logic               flag_c,
    output logic               flag_v,
    output logic [OVC_W-1:0]   ovc
);
    import shsub_pkg::*;

    localparam logic [ACC_W-1:0] SAT_HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_LO = {1'b1, {(ACC_W-1){1'b0}}};

    logic               fire, ld_take;
    logic [OP_W-1:0]    sel_data;
    logic [SHIFT_W-1:0] sel_shift;
    logic               sel_sx, sel_sat;
    logic [ACC_W-1:0]   aligned;
    logic               full_shift;
    logic [ACC_W-1:0]   acc_q, acc_nx;
    flags_t             flg_q, flg_nx;
    logic [OVC_W-1:0]   ovc_q, ovc_nx;
    logic               pos_ovf, neg_ovf;

    shsub_seq #(.OP_W(OP_W), .SHIFT_W(SHIFT_W), .RPT_W(RPT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .op_valid(op_valid),
        .op_data(op_data), .op_shift(op_shift), .sign_ext(sign_ext),
        .sat_mode(sat_mode), .rpt_cnt(rpt_cnt), .fire(fire),
        .ld_take(ld_take), .busy(busy), .sel_data(sel_data),
        .sel_shift(sel_shift), .sel_sx(sel_sx), .sel_sat(sel_sat)
    );

    shsub_align #(.OP_W(OP_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W)) u_align (
        .data_in(sel_data), .shift_in(sel_shift), .sx_in(sel_sx),
        .aligned(aligned), .full_shift(full_shift)
    );

    shsub_core #(.ACC_W(ACC_W), .OVC_W(OVC_W)) u_core (
        .acc_in(acc_q), .c_in(flg_q.c), .v_in(flg_q.v), .ovc_in(ovc_q),
        .opnd(aligned), .full_shift(full_shift), .sat_in(sel_sat),
        .acc_nx(acc_nx), .flags_nx(flg_nx), .ovc_nx(ovc_nx),
        .pos_ovf(pos_ovf), .neg_ovf(neg_ovf)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            flg_q <= '0;
            ovc_q <= '0;
        end else if (ld_take) begin
            acc_q <= ld_acc;
            flg_q <= flags_t'(ld_flags);
            ovc_q <= ld_ovc;
        end else if (fire) begin
            acc_q <= acc_nx;
            flg_q <= flg_nx;
            ovc_q <= ovc_nx;
        end
    end

    assign acc    = acc_q;
    assign flag_z = flg_q.z;
    assign flag_n = flg_q.n;
    assign flag_c = flg_q.c;
    assign flag_v = flg_q.v;
    assign ovc    = ovc_q;

    // R4
    zn_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (flag_z == (acc == '0)) && (flag_n == acc[ACC_W-1]));

    // R7
    v_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_v && !ld_take) |=> flag_v);

    // R9
    sat_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sel_sat && (pos_ovf || neg_ovf)) |=>
            ((acc == SAT_HI || acc == SAT_LO) && $stable(ovc)));

    // R8
    ovc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !sel_sat && !pos_ovf && !neg_ovf) |=> $stable(ovc));

    // R12
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_take |=> (acc == $past(ld_acc) && ovc == $past(ld_ovc)));
endmodule

// File: tb/shacc_sub_unit_test.sv
`timescale 1ns/1ps
module shacc_sub_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_acc = '0;
    logic [3:0]  ld_flags = '0;
    logic [5:0]  ld_ovc = '0;
    logic        op_valid = 1'b0;
    logic [15:0] op_data = '0;
    logic [4:0]  op_shift = '0;
    logic        sign_ext = 1'b0;
    logic        sat_mode = 1'b0;
    logic [7:0]  rpt_cnt = '0;
    logic        busy;
    logic [31:0] acc;
    logic        flag_z, flag_n, flag_c, flag_v;
    logic [5:0]  ovc;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // bench model state
    logic [31:0] m_acc;
    logic        m_z, m_n, m_c, m_v;
    logic [5:0]  m_ovc;
    bit          m_ovf;

    always #2.5 clk = ~clk;

    shacc_sub_unit uut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_acc(ld_acc),
        .ld_flags(ld_flags), .ld_ovc(ld_ovc), .op_valid(op_valid),
        .op_data(op_data), .op_shift(op_shift), .sign_ext(sign_ext),
        .sat_mode(sat_mode), .rpt_cnt(rpt_cnt), .busy(busy), .acc(acc),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v),
        .ovc(ovc)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] dut_state();
        return {20'h0, acc, flag_z, flag_n, flag_c, flag_v, ovc};
    endfunction

    function automatic logic [63:0] mdl_state();
        return {20'h0, m_acc, m_z, m_n, m_c, m_v, m_ovc};
    endfunction

    // arithmetic reference: true signed difference in 64 bits
    task automatic model_op(input logic [15:0] d, input logic [4:0] s,
                            input logic sx, input logic sat);
        logic [31:0] ext, opn;
        int          sa;
        longint      td;
        bit          pos, neg, brw;
        ext = sx ? {{16{d[15]}}, d} : {16'h0, d};
        sa  = (s > 16) ? 16 : int'(s);
        opn = ext << sa;
        td  = longint'($signed(m_acc)) - longint'($signed(opn));
        pos = td > 64'sd2147483647;
        neg = td < -64'sd2147483648;
        brw = m_acc < opn;
        m_ovf = pos || neg;
        if (sa == 16) begin
            if (brw) m_c = 1'b0;
        end else begin
            m_c = !brw;
        end
        if (m_ovf) m_v = 1'b1;
        if (sat && pos)      m_acc = 32'h7FFF_FFFF;
        else if (sat && neg) m_acc = 32'h8000_0000;
        else                 m_acc = m_acc - opn;
        if (!sat && pos) m_ovc = m_ovc + 6'd1;
        if (!sat && neg) m_ovc = m_ovc - 6'd1;
        m_z = (m_acc == 32'h0);
        m_n = m_acc[31];
    endtask

    task automatic preload(input logic [31:0] a, input logic [3:0] f, input logic [5:0] o);
        @(negedge clk);
        ld_en = 1'b1; ld_acc = a; ld_flags = f; ld_ovc = o;
        @(negedge clk);
        ld_en = 1'b0;
        m_acc = a; {m_z, m_n, m_c, m_v} = f; m_ovc = o;
    endtask

    task automatic issue(input logic [15:0] d, input logic [4:0] s,
                         input logic sx, input logic sat, input logic [7:0] r);
        @(negedge clk);
        op_valid = 1'b1; op_data = d; op_shift = s;
        sign_ext = sx; sat_mode = sat; rpt_cnt = r;
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] ops [6];
        logic [31:0] accs [4];
        int          idx;
        ops  = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        accs = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h0001_2345};

        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {31'h0, busy, dut_state()[51:0]}, 64'h0);
        rst_n = 1'b1;

        // R12 load port
        preload(32'hDEAD_BEEF, 4'b1010, 6'h15);
        chk("R12", dut_state(), {20'h0, 32'hDEAD_BEEF, 4'b1010, 6'h15});

        // R12 load wins over a simultaneous request
        @(negedge clk);
        ld_en = 1'b1; ld_acc = 32'h0000_0100; ld_flags = 4'b0001; ld_ovc = 6'h03;
        op_valid = 1'b1; op_data = 16'h0001; op_shift = 5'd0; rpt_cnt = 8'd0;
        @(negedge clk);
        ld_en = 1'b0; op_valid = 1'b0;
        chk("R12", dut_state(), {20'h0, 32'h0000_0100, 4'b0001, 6'h03});

        // sweep: R2 R3 R4 R5 R6 R7 R8 R9 over operands, accumulators, shifts, modes
        idx = 0;
        foreach (ops[oi]) begin
            foreach (accs[ai]) begin
                for (int si = 0; si < 18; si++) begin
                    for (int md = 0; md < 4; md++) begin
                        logic [4:0] sh;
                        string      tag;
                        sh = (si == 17) ? 5'd23 : 5'(si);
                        preload(accs[ai], {2'b00, idx[0], idx[1] & idx[2]}, 6'((idx * 7) & 63));
                        issue(ops[oi], sh, md[0], md[1], 8'd0);
                        model_op(ops[oi], sh, md[0], md[1]);
                        @(negedge clk);
                        op_valid = 1'b0;
                        if (sh >= 5'd16)         tag = "R6 R2";
                        else if (m_ovf && md[1]) tag = "R9 R7";
                        else if (m_ovf)          tag = "R8 R7";
                        else                     tag = "R5 R3 R4";
                        chk(tag, dut_state(), mdl_state());
                        idx++;
                    end
                end
            end
        end

        // R8 counter wraps from +31 to -32
        preload(32'h7FFF_FFFF, 4'b0000, 6'h1F);
        issue(16'h8000, 5'd0, 1'b1, 1'b0, 8'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R8", {58'h0, ovc}, 64'h20);

        // R7 sticky V survives a clean operation
        preload(32'h0000_1000, 4'b0001, 6'h00);
        issue(16'h0001, 5'd0, 1'b0, 1'b0, 8'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7", {63'h0, flag_v}, 64'h1);

        // R10 R11 repeats with competing requests and loads while busy
        for (int rr = 1; rr <= 5; rr += 2) begin
            preload(32'h8002_0005, 4'b0010, 6'h00);
            issue(16'h0001, 5'd16, 1'b0, rr[1], 8'(rr));
            for (int k = 0; k <= rr; k++) model_op(16'h0001, 5'd16, 1'b0, rr[1]);
            @(negedge clk);
            op_data = 16'h7777; op_shift = 5'd3; sign_ext = 1'b1; rpt_cnt = 8'd9;
            ld_en = 1'b1; ld_acc = 32'h1111_1111;
            for (int k = 1; k <= rr; k++) begin
                chk("R10", {63'h0, busy}, 64'h1);
                if (k < rr) @(negedge clk);
            end
            op_valid = 1'b0; ld_en = 1'b0;
            @(negedge clk);
            chk("R10", {63'h0, busy}, 64'h0);
            chk("R11", dut_state(), mdl_state());
        end

        // R10 single op: busy never rises
        preload(32'h0000_0010, 4'b0000, 6'h00);
        issue(16'h0002, 5'd1, 1'b0, 1'b0, 8'd0);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10", {31'h0, busy, acc}, {32'h0, 32'h0000_000C});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule